// File: doc/BRIEF.md
# PHY Discovery and Bring-up Sequencer

This block drives an MDIO management frame master to locate and prepare an Ethernet PHY. A `start` pulse begins a fixed programme. First it scans PHY addresses from zero upward and keeps the first address that answers two reads, one of the status register and one of the control register. It then puts that PHY through a software reset and polls until the reset completes, within a cycle budget. Next it removes electrical isolation and programs the auto-negotiation advertisement. It then enables auto-negotiation and restarts it. Finally it polls the status register until either the link is up or negotiation has completed, also within a budget.

Each register access goes through a one-cycle request and a completion pulse that carries an error flag and read data. The MDIO bit timing belongs to the frame master. Results are held on status outputs until the next `start`: the chosen address, a found flag, reset success, link success and a timeout flag. Delays and budgets are counted in clock cycles and set by parameters.

Top module: `phy_bringup_seq`

## Requirements
- R1: The scan reads status (register 1) and then control (register 0) at each address, starting from address 0 and going up by one. An error on either read moves the scan to the next address without any further access at the current one.
- R2: The first address where both reads complete without error is taken. `phy_found` goes to 1 and `phy_addr` holds that address.
- R3: If none of the `PHY_COUNT` addresses qualifies, the run ends with `phy_found`=0 and `phy_addr`=5'h1F, and it makes no further accesses.
- R4: Reset writes 16'h8000 to control (bit 15 set). The first control poll is issued more than `RST_DLY` cycles after that write is requested. Control is then polled until bit 15 reads 0.
- R5: If bit 15 never clears, the run stops after exactly ceil(`RST_BUDGET`/`RST_DLY`) polls, with `timed_out`=1 and `reset_ok`=0.
- R6: A read error on a reset poll ends the run at once, with `reset_ok`=0 and `timed_out`=0.
- R7: Once bit 15 reads 0, control is read again and written back with bit 10 (isolate) cleared. `reset_ok` goes to 1.
- R8: Set-up follows this order: read control and write it back with bit 12 cleared; read the advertisement (register 4) and write it back ORed with 16'h01E0; read control and write it back with bit 12 set; read control and write it back with bit 9 set. The sequencer does not wait for bit 9 to clear.
- R9: The status register is polled, with successive polls more than `LINK_DLY` cycles apart. With `an_mode`=0 (sampled at start) the poll succeeds on bit 2; with `an_mode`=1 it succeeds on bit 5, and bit 2 is ignored. On success `link_up`=1.
- R10: If the wait condition is never met, the run stops after exactly ceil(`LINK_BUDGET`/`LINK_DLY`) status polls, with `timed_out`=1 and `link_up`=0.
- R11: `mdio_req` is high for one cycle per access. `busy` is high while a run is in progress. `seq_done` pulses for one cycle at the end, after which `busy` is 0.
- R12: After reset: `busy`=0, `phy_found`=0, `phy_addr`=5'h1F, and `reset_ok`, `link_up`, `timed_out` and `mdio_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (ignored while busy) |
| an_mode | input | 1 | 0: wait for link, 1: wait for negotiation complete |
| busy | output | 1 | Run in progress |
| seq_done | output | 1 | One-cycle end-of-run pulse |
| phy_found | output | 1 | A PHY address qualified |
| phy_addr | output | 5 | Selected address, all ones if none |
| reset_ok | output | 1 | PHY reset completed and isolation removed |
| link_up | output | 1 | Wait condition met |
| timed_out | output | 1 | Reset or wait budget ran out |
| mdio_req | output | 1 | Access request pulse to frame master |
| mdio_write | output | 1 | 1 for write, 0 for read |
| mdio_phy | output | 5 | PHY address of the access |
| mdio_reg | output | 5 | Register address of the access |
| mdio_wdata | output | 16 | Write data |
| mdio_done | input | 1 | Access complete pulse |
| mdio_err | input | 1 | Access failed, valid with mdio_done |
| mdio_rdata | input | 16 | Read data, valid with mdio_done |

## Verification
The hardest situations to reach are the two budget exhaustions and the last-address scan. Each needs a PHY model that answers the scan correctly but then never clears its reset bit, or never reports the awaited status bit. The bench's behavioural frame master sits behind the handshake and holds per-scenario state. It can put the only responding PHY at address 31, keep bit 15 high on every reset poll, raise a read error during reset, or report link while withholding negotiation-complete. The full expected access list for each scenario is queued in advance and compared one access at a time.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  localparam logic [4:0] RA_CTRL = 5'd0;
  localparam logic [4:0] RA_STAT = 5'd1;
  localparam logic [4:0] RA_ADV  = 5'd4;

  localparam int CB_RESET   = 15;
  localparam int CB_ANEN    = 12;
  localparam int CB_ISO     = 10;
  localparam int CB_RESTART = 9;
  localparam int SB_LINK    = 2;
  localparam int SB_ANDONE  = 5;

  localparam logic [DATA_W-1:0] ADV_ABILITY = 16'h01E0;

  typedef enum logic [4:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_SCAN_ST, S_SCAN_CT,
    S_RST_WR, S_RST_DLYW, S_RST_POLL, S_ISO_RD, S_ISO_WR,
    S_ANOFF_RD, S_ANOFF_WR, S_ADV_RD, S_ADV_WR, S_ANON_RD,
    S_ANON_WR, S_RS_RD, S_RS_WR, S_LPOLL, S_LDLYW, S_FIN
  } seq_state_e;

  typedef struct packed {
    logic              wr;
    logic [4:0]        ra;
    logic [DATA_W-1:0] data;
  } mdio_cmd_t;

  function automatic mdio_cmd_t mk_cmd(logic wr, logic [4:0] ra, logic [DATA_W-1:0] data);
    mdio_cmd_t c;
    c.wr   = wr;
    c.ra   = ra;
    c.data = data;
    return c;
  endfunction

endpackage

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/phy_seq_budget.sv
module phy_seq_budget #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         consume,
  input  logic [W-1:0] step,
  output logic         exhausted
);
  logic [W-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (load)         left_d = load_val;
    else if (consume) left_d = left_q - step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign exhausted = (left_q <= step);

  // R5 / R10: a poll is only charged while budget remains, so it never wraps
  a_r5_budget_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> !exhausted);

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_seq_pkg::*;
#(
  parameter int PHY_COUNT   = 32,
  parameter int RST_DLY     = 8,
  parameter int RST_BUDGET  = 40,
  parameter int LINK_DLY    = 6,
  parameter int LINK_BUDGET = 30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        an_mode,
  output logic        busy,
  output logic        seq_done,
  output logic        phy_found,
  output logic [4:0]  phy_addr,
  output logic        reset_ok,
  output logic        link_up,
  output logic        timed_out,
  output logic        mdio_req,
  output logic        mdio_write,
  output logic [4:0]  mdio_phy,
  output logic [4:0]  mdio_reg,
  output logic [15:0] mdio_wdata,
  input  logic        mdio_done,
  input  logic        mdio_err,
  input  logic [15:0] mdio_rdata
);
  localparam int DLY_MAX = (RST_DLY > LINK_DLY) ? RST_DLY : LINK_DLY;
  localparam int BUD_MAX = (RST_BUDGET > LINK_BUDGET) ? RST_BUDGET : LINK_BUDGET;
  localparam int TW = $clog2(DLY_MAX + 1);
  localparam int BW = $clog2(((BUD_MAX > DLY_MAX) ? BUD_MAX : DLY_MAX) + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(PHY_COUNT - 1);

  seq_state_e        state_q, state_d, ret_q, ret_d;
  mdio_cmd_t         cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] rsp_q;
  logic              rsp_err_q;
  logic              found_q, found_d, rok_q, rok_d, link_q, link_d, tmo_q, tmo_d;
  logic              mode_q, mode_d;
  logic              scan_miss;
  logic              tmr_load, tmr_zero;
  logic [TW-1:0]     tmr_val;
  logic              bud_load, bud_cons, bud_exh;
  logic [BW-1:0]     bud_val, bud_step;
  logic              hit;

  phy_seq_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  phy_seq_budget #(.W(BW)) u_budget (
    .clk(clk), .rst_n(rst_n), .load(bud_load), .load_val(bud_val),
    .consume(bud_cons), .step(bud_step), .exhausted(bud_exh)
  );

  assign bud_step = (state_q == S_RST_POLL) ? BW'(RST_DLY) : BW'(LINK_DLY);
  assign hit      = mode_q ? rsp_q[SB_ANDONE] : rsp_q[SB_LINK];

  always_comb begin
    state_d = state_q; ret_d = ret_q; cmd_d = cmd_q; addr_d = addr_q;
    found_d = found_q; rok_d = rok_q; link_d = link_q; tmo_d = tmo_q; mode_d = mode_q;
    scan_miss = 1'b0;
    tmr_load = 1'b0; tmr_val = '0;
    bud_load = 1'b0; bud_val = '0; bud_cons = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) begin
        addr_d = '0; found_d = 1'b0; rok_d = 1'b0; link_d = 1'b0; tmo_d = 1'b0;
        mode_d = an_mode;
        cmd_d = mk_cmd(1'b0, RA_STAT, '0); ret_d = S_SCAN_ST; state_d = S_ISSUE;
      end
      S_ISSUE: state_d = S_WAIT;
      S_WAIT:  if (mdio_done) state_d = ret_q;
      S_SCAN_ST: begin
        if (rsp_err_q) scan_miss = 1'b1;
        else begin cmd_d = mk_cmd(1'b0, RA_CTRL, '0); ret_d = S_SCAN_CT; state_d = S_ISSUE; end
      end
      S_SCAN_CT: begin
        if (rsp_err_q) scan_miss = 1'b1;
        else begin
          found_d = 1'b1;
          cmd_d = mk_cmd(1'b1, RA_CTRL, 16'h1 << CB_RESET); ret_d = S_RST_WR; state_d = S_ISSUE;
        end
      end
      S_RST_WR: begin
        tmr_load = 1'b1; tmr_val = TW'(RST_DLY);
        bud_load = 1'b1; bud_val = BW'(RST_BUDGET);
        state_d = S_RST_DLYW;
      end
      S_RST_DLYW: if (tmr_zero) begin
        cmd_d = mk_cmd(1'b0, RA_CTRL, '0); ret_d = S_RST_POLL; state_d = S_ISSUE;
      end
      S_RST_POLL: begin
        if (rsp_err_q) state_d = S_FIN;
        else if (!rsp_q[CB_RESET]) begin
          cmd_d = mk_cmd(1'b0, RA_CTRL, '0); ret_d = S_ISO_RD; state_d = S_ISSUE;
        end else if (bud_exh) begin
          tmo_d = 1'b1; state_d = S_FIN;
        end else begin
          bud_cons = 1'b1; tmr_load = 1'b1; tmr_val = TW'(RST_DLY); state_d = S_RST_DLYW;
        end
      end
      S_ISO_RD: begin
        rok_d = 1'b1;
        cmd_d = mk_cmd(1'b1, RA_CTRL, rsp_q & ~(16'h1 << CB_ISO)); ret_d = S_ISO_WR; state_d = S_ISSUE;
      end
      S_ISO_WR:   begin cmd_d = mk_cmd(1'b0, RA_CTRL, '0); ret_d = S_ANOFF_RD; state_d = S_ISSUE; end
      S_ANOFF_RD: begin
        cmd_d = mk_cmd(1'b1, RA_CTRL, rsp_q & ~(16'h1 << CB_ANEN)); ret_d = S_ANOFF_WR; state_d = S_ISSUE;
      end
      S_ANOFF_WR: begin cmd_d = mk_cmd(1'b0, RA_ADV, '0); ret_d = S_ADV_RD; state_d = S_ISSUE; end
      S_ADV_RD:   begin cmd_d = mk_cmd(1'b1, RA_ADV, rsp_q | ADV_ABILITY); ret_d = S_ADV_WR; state_d = S_ISSUE; end
      S_ADV_WR:   begin cmd_d = mk_cmd(1'b0, RA_CTRL, '0); ret_d = S_ANON_RD; state_d = S_ISSUE; end
      S_ANON_RD:  begin
        cmd_d = mk_cmd(1'b1, RA_CTRL, rsp_q | (16'h1 << CB_ANEN)); ret_d = S_ANON_WR; state_d = S_ISSUE;
      end
      S_ANON_WR:  begin cmd_d = mk_cmd(1'b0, RA_CTRL, '0); ret_d = S_RS_RD; state_d = S_ISSUE; end
      S_RS_RD:    begin
        cmd_d = mk_cmd(1'b1, RA_CTRL, rsp_q | (16'h1 << CB_RESTART)); ret_d = S_RS_WR; state_d = S_ISSUE;
      end
      S_RS_WR: begin
        bud_load = 1'b1; bud_val = BW'(LINK_BUDGET);
        cmd_d = mk_cmd(1'b0, RA_STAT, '0); ret_d = S_LPOLL; state_d = S_ISSUE;
      end
      S_LPOLL: begin
        if (rsp_err_q) state_d = S_FIN;
        else if (hit) begin link_d = 1'b1; state_d = S_FIN; end
        else if (bud_exh) begin tmo_d = 1'b1; state_d = S_FIN; end
        else begin
          bud_cons = 1'b1; tmr_load = 1'b1; tmr_val = TW'(LINK_DLY); state_d = S_LDLYW;
        end
      end
      S_LDLYW: if (tmr_zero) begin
        cmd_d = mk_cmd(1'b0, RA_STAT, '0); ret_d = S_LPOLL; state_d = S_ISSUE;
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if (scan_miss) begin
      if (addr_q == LAST_ADDR) begin
        addr_d = '1; state_d = S_FIN;
      end else begin
        addr_d = addr_q + 1'b1;
        cmd_d = mk_cmd(1'b0, RA_STAT, '0); ret_d = S_SCAN_ST; state_d = S_ISSUE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; ret_q <= S_IDLE; cmd_q <= '0; addr_q <= '1;
      found_q <= 1'b0; rok_q <= 1'b0; link_q <= 1'b0; tmo_q <= 1'b0; mode_q <= 1'b0;
    end else begin
      state_q <= state_d; ret_q <= ret_d; cmd_q <= cmd_d; addr_q <= addr_d;
      found_q <= found_d; rok_q <= rok_d; link_q <= link_d; tmo_q <= tmo_d; mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= '0; rsp_err_q <= 1'b0;
    end else if (state_q == S_WAIT && mdio_done) begin
      rsp_q <= mdio_rdata; rsp_err_q <= mdio_err;
    end
  end

  assign busy       = (state_q != S_IDLE);
  assign seq_done   = (state_q == S_FIN);
  assign phy_found  = found_q;
  assign phy_addr   = addr_q;
  assign reset_ok   = rok_q;
  assign link_up    = link_q;
  assign timed_out  = tmo_q;
  assign mdio_req   = (state_q == S_ISSUE);
  assign mdio_write = cmd_q.wr;
  assign mdio_phy   = addr_q;
  assign mdio_reg   = cmd_q.ra;
  assign mdio_wdata = cmd_q.data;

  a_r11_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req |=> !mdio_req);
  a_r11_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !busy);
  a_r3_miss_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !phy_found) |-> (phy_addr == '1));
  a_r7_ok_needs_found: assert property (@(posedge clk) disable iff (!rst_n)
    reset_ok |-> phy_found);
  a_r10_link_or_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_up && timed_out));

endmodule

// File: tb/phy_bringup_seq_test.sv
module phy_bringup_seq_test;
  localparam int PHY_COUNT = 32, RST_DLY = 8, RST_BUDGET = 40, LINK_DLY = 6, LINK_BUDGET = 30;

  logic clk, rst_n, start, an_mode;
  logic busy, seq_done, phy_found, reset_ok, link_up, timed_out;
  logic [4:0] phy_addr, mdio_phy, mdio_reg;
  logic mdio_req, mdio_write, mdio_done, mdio_err;
  logic [15:0] mdio_wdata, mdio_rdata;

  phy_bringup_seq #(.PHY_COUNT(PHY_COUNT), .RST_DLY(RST_DLY), .RST_BUDGET(RST_BUDGET),
                    .LINK_DLY(LINK_DLY), .LINK_BUDGET(LINK_BUDGET)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .an_mode(an_mode), .busy(busy),
    .seq_done(seq_done), .phy_found(phy_found), .phy_addr(phy_addr), .reset_ok(reset_ok),
    .link_up(link_up), .timed_out(timed_out), .mdio_req(mdio_req), .mdio_write(mdio_write),
    .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata), .mdio_done(mdio_done),
    .mdio_err(mdio_err), .mdio_rdata(mdio_rdata));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct { logic [26:0] cmd; string tag; } item_t;
  item_t exp_q[$];
  int checks = 0, fails = 0, cyc = 0;

  // PHY model configuration and state
  int present, half, rst_polls, rst_left, st_after, st_cnt, lat;
  bit stuck, err_rst, restarted;
  logic [15:0] st_bits, st_always, ctrl, adv, pend_data;
  logic pend_err;
  logic [26:0] prev_cmd;
  int prev_cyc;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(string tag, logic wr, int a, logic [4:0] r, logic [15:0] d);
    item_t it;
    it.cmd = {wr, 5'(a), r, d};
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic cfg(int p, int h, int rp, bit stk, bit er, int sa, logic [15:0] sb, logic [15:0] sal);
    present = p; half = h; rst_polls = rp; stuck = stk; err_rst = er;
    st_after = sa; st_bits = sb; st_always = sal;
    rst_left = 0; st_cnt = 0; restarted = 0; ctrl = 16'h1000; adv = 16'h0001;
  endtask

  task automatic push_scan(int p, int h);
    for (int a = 0; a <= p; a++) begin
      if (a == p) begin push("R2", 0, a, 1, 0); push("R2", 0, a, 0, 0); end
      else if (a == h) begin push("R1", 0, a, 1, 0); push("R1", 0, a, 0, 0); end
      else push("R1", 0, a, 1, 0);
    end
  endtask

  task automatic push_reset(int a, int n);
    push("R4", 1, a, 0, 16'h8000);
    for (int i = 0; i < n; i++) push("R5", 0, a, 0, 0);
  endtask

  task automatic push_init(int a);
    push("R7", 0, a, 0, 0); push("R7", 1, a, 0, 16'h3000);
    push("R8", 0, a, 0, 0); push("R8", 1, a, 0, 16'h2000);
    push("R8", 0, a, 4, 0); push("R8", 1, a, 4, 16'h01E1);
    push("R8", 0, a, 0, 0); push("R8", 1, a, 0, 16'h3000);
    push("R8", 0, a, 0, 0); push("R8", 1, a, 0, 16'h3200);
  endtask

  task automatic push_polls(int a, int n);
    for (int i = 0; i < n; i++) push("R9", 0, a, 1, 0);
  endtask

  task automatic respond(logic wr, int a, logic [4:0] r, logic [15:0] d);
    pend_err = 1'b0; pend_data = 16'hFFFF;
    if (a == present) begin
      if (r == 0) begin
        if (wr) begin
          if (d[15]) begin ctrl = 16'h3400; rst_left = rst_polls; end
          else begin ctrl = d; if (d[9]) restarted = 1; end
        end else if (rst_left > 0) begin
          pend_err = err_rst; pend_data = ctrl | 16'h8000;
          if (!stuck) rst_left--;
        end else pend_data = ctrl;
      end else if (r == 1) begin
        pend_data = 16'h7809 | st_always | ((restarted && st_cnt >= st_after) ? st_bits : 16'h0);
        if (restarted) st_cnt++;
      end else if (r == 4) begin
        if (wr) adv = d; else pend_data = adv;
      end
    end else if (a == half && !wr && r == 1) pend_data = 16'h7809;
    else pend_err = 1'b1;
  endtask

  // frame-master model plus scoreboard monitor
  initial begin
    mdio_done = 0; mdio_err = 0; mdio_rdata = 0; lat = 0; prev_cmd = '0; prev_cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      mdio_done = 1'b0;
      if (lat == 1) begin mdio_done = 1'b1; mdio_rdata = pend_data; mdio_err = pend_err; end
      if (lat > 0) lat--;
      if (mdio_req) begin
        logic [26:0] got;
        got = {mdio_write, mdio_phy, mdio_reg, mdio_write ? mdio_wdata : 16'h0};
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R11 unexpected access: actual=%0h expected=none", got);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk(it.tag, "access", int'(got), int'(it.cmd));
        end
        if (got[26] == 0 && got[20:16] == 0 && prev_cmd == {1'b1, got[25:21], 5'd0, 16'h8000})
          chk("R4", "reset delay gap", int'((cyc - prev_cyc) > RST_DLY), 1);
        if (got[26] == 0 && got[20:16] == 1 && prev_cmd == got && restarted)
          chk("R9", "poll gap", int'((cyc - prev_cyc) > LINK_DLY), 1);
        respond(mdio_write, int'(mdio_phy), mdio_reg, mdio_wdata);
        prev_cmd = got; prev_cyc = cyc;
        lat = 2;
      end
    end
  end

  task automatic run(bit mode, string tag, bit ef, int ea, bit eok, bit elink, bit etmo);
    @(negedge clk);
    start = 1'b1; an_mode = mode;
    @(negedge clk);
    start = 1'b0;
    chk("R11", "busy during run", int'(busy), 1);
    while (!seq_done) @(negedge clk);
    chk(tag, "phy_found", int'(phy_found), int'(ef));
    chk(tag, "phy_addr", int'(phy_addr), ea);
    chk(tag, "reset_ok", int'(reset_ok), int'(eok));
    chk(tag, "link_up", int'(link_up), int'(elink));
    chk(tag, "timed_out", int'(timed_out), int'(etmo));
    chk(tag, "accesses left", exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    chk("R11", "done pulse width", int'(seq_done), 0);
    chk("R11", "busy after done", int'(busy), 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; start = 0; an_mode = 0;
    cfg(99, 99, 0, 0, 0, 0, 16'h0, 16'h0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12", "busy", int'(busy), 0);
    chk("R12", "phy_found", int'(phy_found), 0);
    chk("R12", "phy_addr", int'(phy_addr), 31);
    chk("R12", "flags", int'({reset_ok, link_up, timed_out, mdio_req}), 0);

    // full bring-up, link mode, PHY at 3, address 1 fails its control read
    cfg(3, 1, 2, 0, 0, 2, 16'h0004, 16'h0);
    push_scan(3, 1); push_reset(3, 3); push_init(3); push_polls(3, 3);
    run(0, "R2", 1, 3, 1, 1, 0);

    // nothing answers
    cfg(99, 99, 0, 0, 0, 0, 16'h0, 16'h0);
    for (int a = 0; a < PHY_COUNT; a++) push("R3", 0, a, 1, 0);
    run(0, "R3", 0, 31, 0, 0, 0);

    // reset bit never clears
    cfg(0, 99, 1, 1, 0, 0, 16'h0, 16'h0);
    push_scan(0, 99); push_reset(0, (RST_BUDGET + RST_DLY - 1) / RST_DLY);
    run(0, "R5", 1, 0, 0, 0, 1);

    // read error while polling reset
    cfg(0, 99, 1, 0, 1, 0, 16'h0, 16'h0);
    push_scan(0, 99); push_reset(0, 1);
    run(0, "R6", 1, 0, 0, 0, 0);

    // negotiation mode at the last address: link shown but negotiation never completes
    cfg(31, 99, 0, 0, 0, 0, 16'h0, 16'h0004);
    push_scan(31, 99); push_reset(31, 1); push_init(31);
    push_polls(31, (LINK_BUDGET + LINK_DLY - 1) / LINK_DLY);
    run(1, "R10", 1, 31, 1, 0, 1);

    // negotiation mode success on second poll
    cfg(0, 99, 0, 0, 0, 1, 16'h0020, 16'h0004);
    push_scan(0, 99); push_reset(0, 1); push_init(0); push_polls(0, 2);
    run(1, "R9", 1, 0, 1, 1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule